// File: doc/BRIEF.md
# Byte-Wide Boot ROM Loader

This block copies a boot image from an external byte-wide ROM into on-chip memory with no help from a processor. Once reset is released it starts by itself. It walks a 24-bit byte address upward from a strapped start address and drives a read strobe and a select line to the ROM. Each read is held for a fixed number of wait cycles before the byte is captured. Four captured bytes are merged into a 32-bit word, and the word is handed to an internal memory write port as a one-cycle pulse.

The image length is given in words by a strapped count. When the last word has been written, a done flag rises and stays high. The ROM select line then returns to its idle level for good, so the pin is free for other use after boot. The start address and the count are taken in the first clock cycle after reset and must stay stable while reset is asserted.

Top module: `boot_byte_loader`

## Requirements
- R1: While `rst_n` is low, the select is inactive (`rom_sel` = 1 with the default active-low polarity), `rom_rd_n` = 1, `mem_wr_valid` = 0 and `boot_done` = 0.
- R2: With a non-zero word count, `rom_rd_n` is low after the first rising clock edge that follows reset release, and `rom_addr` then equals `cfg_start_addr`. No other input is needed to start.
- R3: Each byte access keeps `rom_rd_n` low and `rom_addr` constant for exactly WAIT_CYC (default 16) cycles. `rom_data` is captured at the rising edge that ends the last of those cycles.
- R4: Successive byte addresses rise by one from `cfg_start_addr` and wrap modulo 2^24.
- R5: Bytes are packed little-endian: the first byte of a word lands in `mem_wr_data[7:0]`, the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R6: After the fourth byte of a word is captured, `mem_wr_valid` is high for exactly one cycle, with `rom_rd_n` high in that cycle. `mem_wr_addr` is 0 for the first word and rises by one for each word after it.
- R7: Exactly `cfg_word_count` writes occur. `boot_done` rises in the cycle right after the last write pulse and stays high until reset. From then on there are no reads and no writes.
- R8: With `cfg_word_count` = 0, `boot_done` is high after the first rising edge that follows reset release, and no read is ever issued.
- R9: The select is active (low by default) whenever `rom_rd_n` is low and during every write cycle of the boot. It is inactive before the boot starts and once `boot_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_addr | input | 24 | Strapped byte address of the first image byte |
| cfg_word_count | input | 16 | Strapped image length in 32-bit words |
| rom_addr | output | 24 | Byte address to the ROM |
| rom_sel | output | 1 | ROM select, active low by default |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_data | input | 8 | Byte returned by the ROM |
| mem_wr_valid | output | 1 | One-cycle internal memory write pulse |
| mem_wr_addr | output | 16 | Word address of the write |
| mem_wr_data | output | 32 | Packed word |
| boot_done | output | 1 | Boot complete, held until reset |

## Verification
A wait counter that runs off by even one cycle shows up on the very first byte. The strobe segment has the wrong length, and the bench ROM returns a poison byte in every cycle except the sixteenth, so the first written word is corrupted. A wrong lane index or address pointer shows up in the first write pulse, about 65 cycles into the boot, as a swapped or shifted byte. A wrong word counter shows up at the end, as an early or late `boot_done` edge or a write pulse after completion.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2,
      ST_DONE  = 2'd3
   } boot_state_e;
endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
   parameter int WAIT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

   generate
      if (WAIT_CYC == 1) begin : g_single
         // every strobe cycle ends an access
         assign expire = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign expire = run && (cnt == CW'(WAIT_CYC - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt <= '0;
            else if (!run || expire) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/boot_byte_packer.sv
module boot_byte_packer #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [BYTE_W-1:0]       byte_in,
   output logic                    lane_last,
   output logic [LANES*BYTE_W-1:0] word_out
);
   localparam int LW = $clog2(LANES);

   logic [LW-1:0] lane_idx;

   assign lane_last = (lane_idx == LW'(LANES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    lane_idx <= '0;
      else if (load) lane_idx <= lane_last ? '0 : lane_idx + 1'b1;
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_out[i*BYTE_W +: BYTE_W] <= '0;
            else if (load && lane_idx == LW'(i))
               word_out[i*BYTE_W +: BYTE_W] <= byte_in;
         end
      end
   endgenerate
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
   import boot_ldr_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic [CNT_W-1:0]  cfg_word_count,
   input  logic              byte_done,
   input  logic              lane_last,
   output logic              fetch,
   output logic              store,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] byte_ptr,
   output logic [CNT_W-1:0]  word_idx
);
   boot_state_e   state;
   logic [CNT_W-1:0] count_q;

   assign fetch = (state == ST_FETCH);
   assign store = (state == ST_STORE);
   assign busy  = fetch || store;
   assign done  = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         byte_ptr <= '0;
         word_idx <= '0;
         count_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               byte_ptr <= cfg_start_addr;
               count_q  <= cfg_word_count;
               word_idx <= '0;
               state    <= (cfg_word_count == '0) ? ST_DONE : ST_FETCH;
            end
            ST_FETCH: begin
               if (byte_done) begin
                  byte_ptr <= byte_ptr + 1'b1;
                  if (lane_last) state <= ST_STORE;
               end
            end
            ST_STORE: begin
               word_idx <= word_idx + 1'b1;
               state    <= (word_idx == count_q - 1'b1) ? ST_DONE : ST_FETCH;
            end
            default: state <= ST_DONE;
         endcase
      end
   end
endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
   parameter int ADDR_W        = 24,
   parameter int WORD_W        = 32,
   parameter int CNT_W         = 16,
   parameter int MEM_AW        = 16,
   parameter int WAIT_CYC      = 16,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic [CNT_W-1:0]  cfg_word_count,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              rom_sel,
   output logic              rom_rd_n,
   input  logic [7:0]        rom_data,
   output logic              mem_wr_valid,
   output logic [MEM_AW-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data,
   output logic              boot_done
);
   localparam int BYTE_W = 8;
   localparam int LANES  = WORD_W / BYTE_W;

   generate
      if (WORD_W % BYTE_W != 0 || LANES < 2) begin : g_bad_word
         $error("WORD_W must be a multiple of 8 holding at least two bytes");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("WAIT_CYC must be at least 1");
      end
      if (CNT_W > MEM_AW) begin : g_bad_cnt
         $error("MEM_AW must cover every word index");
      end
   endgenerate

   logic fetch, store, busy, done, byte_done, lane_last;
   logic [ADDR_W-1:0] byte_ptr;
   logic [CNT_W-1:0]  word_idx;

   boot_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_start_addr (cfg_start_addr),
      .cfg_word_count (cfg_word_count),
      .byte_done      (byte_done),
      .lane_last      (lane_last),
      .fetch          (fetch),
      .store          (store),
      .busy           (busy),
      .done           (done),
      .byte_ptr       (byte_ptr),
      .word_idx       (word_idx)
   );

   boot_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (fetch),
      .expire (byte_done)
   );

   boot_byte_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (byte_done),
      .byte_in   (rom_data),
      .lane_last (lane_last),
      .word_out  (mem_wr_data)
   );

   generate
      if (CS_ACTIVE_LOW) begin : g_sel_low
         assign rom_sel = ~busy;
      end else begin : g_sel_high
         assign rom_sel = busy;
      end
   endgenerate

   assign rom_rd_n     = ~fetch;
   assign rom_addr     = byte_ptr;
   assign mem_wr_valid = store;
   assign mem_wr_addr  = MEM_AW'(word_idx);
   assign boot_done    = done;
endmodule

// File: rtl/boot_byte_loader_chk.sv
module boot_byte_loader_chk #(
   parameter int ADDR_W        = 24,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              rom_sel,
   input logic              rom_rd_n,
   input logic              mem_wr_valid,
   input logic              boot_done
);
   logic sel_on;
   assign sel_on = (rom_sel != CS_ACTIVE_LOW);

   assert_rd_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_rd_n |-> sel_on);

   assert_sel_off_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> !sel_on);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_rd_n && $past(!rom_rd_n) && $past(rst_n)) |-> ($stable(rom_addr) || rom_addr == $past(rom_addr) + 1'b1));

   assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |=> !mem_wr_valid);

   assert_no_rd_on_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> rom_rd_n);

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> (rom_rd_n && !mem_wr_valid));
endmodule

bind boot_byte_loader boot_byte_loader_chk #(
   .ADDR_W        (ADDR_W),
   .CS_ACTIVE_LOW (CS_ACTIVE_LOW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rom_addr     (rom_addr),
   .rom_sel      (rom_sel),
   .rom_rd_n     (rom_rd_n),
   .mem_wr_valid (mem_wr_valid),
   .boot_done    (boot_done)
);

// File: tb/boot_byte_loader_tb.sv
module boot_byte_loader_tb;
   localparam int WAIT = 16;

   typedef struct packed {
      logic [23:0] start;
      logic [15:0] count;
   } cfg_t;

   localparam cfg_t CFGS [5] = '{
      '{24'h000100, 16'd1},
      '{24'h012340, 16'd3},
      '{24'hFFFFFD, 16'd2},
      '{24'h000000, 16'd0},
      '{24'h7A0003, 16'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cfg_start_addr = '0;
   logic [15:0] cfg_word_count = '0;
   logic [23:0] rom_addr;
   logic        rom_sel, rom_rd_n, mem_wr_valid, boot_done;
   logic [7:0]  rom_data = 8'hEE;
   logic [15:0] mem_wr_addr;
   logic [31:0] mem_wr_data;

   int n_checks = 0, n_fail = 0;
   int cyc = 0, run = 0, wr_seen = 0, last_wr_cyc = 0, rd_seen = 0;
   logic [23:0] prev_addr = '0, last_rd_addr = '0;
   logic prev_rd_n = 1'b1, prev_done = 1'b0;

   always #5 clk = ~clk;

   boot_byte_loader u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_start_addr (cfg_start_addr),
      .cfg_word_count (cfg_word_count),
      .rom_addr       (rom_addr),
      .rom_sel        (rom_sel),
      .rom_rd_n       (rom_rd_n),
      .rom_data       (rom_data),
      .mem_wr_valid   (mem_wr_valid),
      .mem_wr_addr    (mem_wr_addr),
      .mem_wr_data    (mem_wr_data),
      .boot_done      (boot_done)
   );

   function automatic logic [7:0] rom_byte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5 ^ {a[2:0], 5'b0};
   endfunction

   function automatic logic [31:0] exp_word(input logic [23:0] s, input int k);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[j*8 +: 8] = rom_byte(s + 24'(4*k + j));
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ROM model and on-the-fly monitor, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         run = 0; prev_rd_n = 1'b1; prev_done = 1'b0;
         rom_data <= 8'hEE;
      end else begin
         if (!prev_rd_n && (rom_rd_n || rom_addr != prev_addr))
            check(run == WAIT, "R3", 64'(run), 64'(WAIT));
         if (!rom_rd_n) begin
            if (prev_rd_n || rom_addr != prev_addr) begin
               if (rd_seen == 0)
                  check(rom_addr == cfg_start_addr, "R4", 64'(rom_addr), 64'(cfg_start_addr));
               else
                  check(rom_addr == last_rd_addr + 24'd1, "R4", 64'(rom_addr), 64'(last_rd_addr + 24'd1));
               rd_seen++;
               last_rd_addr = rom_addr;
               run = 1;
               check(rom_sel == 1'b0, "R9", 64'(rom_sel), 64'd0);
            end else run++;
         end else run = 0;
         rom_data <= (!rom_rd_n && run == WAIT) ? rom_byte(rom_addr) : 8'hEE;
         if (mem_wr_valid) begin
            check(mem_wr_data == exp_word(cfg_start_addr, wr_seen), "R5",
                  64'(mem_wr_data), 64'(exp_word(cfg_start_addr, wr_seen)));
            check(mem_wr_addr == 16'(wr_seen) && rom_rd_n && rom_sel == 1'b0, "R6",
                  64'(mem_wr_addr), 64'(wr_seen));
            wr_seen++;
            last_wr_cyc = cyc;
            check(wr_seen <= int'(cfg_word_count), "R7", 64'(wr_seen), 64'(cfg_word_count));
         end
         if (boot_done && !prev_done && cfg_word_count != 0)
            check(cyc == last_wr_cyc + 1, "R7", 64'(cyc), 64'(last_wr_cyc + 1));
         prev_rd_n = rom_rd_n;
         prev_addr = rom_addr;
         prev_done = boot_done;
      end
   end

   task automatic apply_reset(input logic [23:0] s, input logic [15:0] c);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_start_addr = s;
      cfg_word_count = c;
      repeat (3) @(negedge clk);
      // R1: idle outputs during reset
      check(rom_sel == 1'b1 && rom_rd_n && !mem_wr_valid && !boot_done, "R1",
            64'({rom_sel, rom_rd_n, mem_wr_valid, boot_done}), 64'b1100);
      wr_seen = 0; rd_seen = 0;
   endtask

   task automatic run_boot(input logic [23:0] s, input logic [15:0] c);
      int guard;
      apply_reset(s, c);
      rst_n = 1'b1;
      @(negedge clk);
      if (c != 0) begin
         check(!rom_rd_n && rom_addr == s, "R2", 64'({rom_rd_n, rom_addr}), 64'({1'b0, s}));
      end else begin
         check(boot_done && rom_rd_n, "R8", 64'({boot_done, rom_rd_n}), 64'b11);
      end
      guard = 0;
      while (!boot_done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      check(boot_done == 1'b1, "R7", 64'(boot_done), 64'd1);
      check(wr_seen == int'(c), "R7", 64'(wr_seen), 64'(c));
      repeat (10) @(negedge clk);
      check(boot_done && rom_rd_n && rom_sel == 1'b1 && wr_seen == int'(c), "R9",
            64'({boot_done, rom_rd_n, rom_sel}), 64'b111);
      if (c == 0) check(rd_seen == 0, "R8", 64'(rd_seen), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 5; i++) run_boot(CFGS[i].start, CFGS[i].count);

      // directed: reset in the middle of a boot returns to idle (R1), then restart (R2)
      apply_reset(24'h000400, 16'd3);
      rst_n = 1'b1;
      repeat (90) @(negedge clk);
      check(wr_seen == 1 && !boot_done, "R6", 64'(wr_seen), 64'd1);
      rst_n = 1'b0;
      @(negedge clk);
      check(rom_sel == 1'b1 && rom_rd_n && !mem_wr_valid && !boot_done, "R1",
            64'({rom_sel, rom_rd_n, mem_wr_valid, boot_done}), 64'b1100);
      run_boot(24'h000400, 16'd3);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule